// File: doc/BRIEF.md
# Size-Aware Condition Flag Updater

This block owns the eight-bit processor condition flag byte and rewrites part of it after each arithmetic or logic step. The datapath hands it a result value, the operand width in bytes (one to four), a carry bit and a command. The command names the subset of overflow, sign, zero and carry flags that the step affects. The unit derives those flags from the result at the chosen width and merges them into the stored byte. Every flag outside the subset keeps its old value. The result arrives as a 33-bit two's-complement number, so a 32-bit operation that left the signed range can still be seen as out of range.

Overflow has two rules, chosen by the command. The range rule flags a result that lies outside the signed range of the operand width. The extension rule flags a result whose bits above the operand width are neither all zero nor all one. A separate masked write lets the control logic set or clear any flag bits directly, including the flags that no command touches.

Top module: `flag_update_unit`

## Requirements
- R1: While `rst_n` is low, `flags_q` is 0x00, and it stays 0x00 until a strobe arrives.
- R2: The flag byte holds carry at bit 0, decimal-mode at bit 1, zero at bit 2, sign at bit 3, register-bank at bit 4, overflow at bit 5, interrupt-enable at bit 6 and stack-select at bit 7. An update never changes bits 1, 4, 6 or 7.
- R3: On a clock edge with `upd_en` high and `wr_en` low, `cmd` selects the flags that are rewritten: 0 = O,S,Z,C; 1 = S,Z,C; 2 = O,S,Z; 3 = S,Z; 4 = Z,C; 5 = C only. Codes 6 and 7 change nothing. Flags outside the subset keep their values.
- R4: The zero flag becomes 1 exactly when the low 8×N bits of `result` are all zero, where N is the operand width in bytes.
- R5: The sign flag becomes bit 8×N−1 of `result`.
- R6: For command 0, the overflow flag becomes 1 when `result`, read as a signed value, is greater than 2^(8N−1)−1 or less than −2^(8N−1).
- R7: For command 2, the overflow flag becomes 1 when the bits of `result` above bit 8×N−1 are neither all zero nor all one. At N = 4 this rule never sets overflow.
- R8: Whenever the carry flag is in the selected subset, it becomes `carry_in`.
- R9: On a clock edge with `wr_en` high, every bit set in `wr_mask` takes the matching bit of `wr_bits`. Every other bit keeps its value.
- R10: When `wr_en` and `upd_en` are both high on the same edge, only the masked write takes effect.
- R11: On an edge with both strobes low, `flags_q` does not change.
- R12: `size_sel` gives the operand width as N−1: 0 = 1 byte, 1 = 2 bytes, 2 = 3 bytes, 3 = 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Strobe that applies a result-driven flag update |
| cmd | input | 3 | Selects the flag subset and the overflow rule |
| size_sel | input | 2 | Operand width in bytes, minus one |
| result | input | 33 | Signed result value from the datapath |
| carry_in | input | 1 | Carry produced by the datapath |
| wr_en | input | 1 | Strobe for a direct masked write |
| wr_mask | input | 8 | Flag bits affected by the direct write |
| wr_bits | input | 8 | New values for the masked bits |
| flags_q | output | 8 | Stored flag byte |

## Verification
The assertions assume that `result` is a proper sign extension of a value that fits in 33 bits. They also assume that all inputs are known and stable around each rising edge. The bench drives every input on the falling edge and builds each result from a signed integer cut to 33 bits. It therefore never presents an unknown value or an ill-formed input. The bench also aims for the cases that separate the two overflow rules, for example 0xFF at one byte and 2^31 at four bytes. It reaches those cases with both strobes held low or with only one strobe high, except in the scenario that checks the priority between the two strobes.

// File: rtl/flag_update_unit.sv
module flag_update_unit #(
  parameter int MAX_BYTES = 4,
  localparam int RES_W = 8 * MAX_BYTES + 1,
  localparam int SZW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [2:0]       cmd,
  input  logic [SZW-1:0]   size_sel,
  input  logic [RES_W-1:0] result,
  input  logic             carry_in,
  input  logic             wr_en,
  input  logic [7:0]       wr_mask,
  input  logic [7:0]       wr_bits,
  output logic [7:0]       flags_q
);

  localparam int BIT_C = 0;
  localparam int BIT_Z = 2;
  localparam int BIT_S = 3;
  localparam int BIT_O = 5;

  typedef enum logic [2:0] {
    CMD_OSZC = 3'd0,
    CMD_SZC  = 3'd1,
    CMD_OSZ  = 3'd2,
    CMD_SZ   = 3'd3,
    CMD_ZC   = 3'd4,
    CMD_C    = 3'd5
  } upd_cmd_e;

  logic [MAX_BYTES-1:0] zero_v, sign_v, ovr_range_v, ovr_ext_v;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    localparam int W = 8 * (g + 1);
    assign zero_v[g]      = ~|result[W-1:0];
    assign sign_v[g]      = result[W-1];
    assign ovr_range_v[g] = ~((&result[RES_W-1:W-1]) | ~(|result[RES_W-1:W-1]));
    assign ovr_ext_v[g]   = ~((&result[RES_W-1:W]) | ~(|result[RES_W-1:W]));
  end

  logic [7:0] sel_mask, calc;
  logic       ovr_sel;

  assign ovr_sel = (cmd == CMD_OSZC) ? ovr_range_v[size_sel] : ovr_ext_v[size_sel];

  always_comb begin
    calc        = '0;
    calc[BIT_C] = carry_in;
    calc[BIT_Z] = zero_v[size_sel];
    calc[BIT_S] = sign_v[size_sel];
    calc[BIT_O] = ovr_sel;
  end

  always_comb begin
    sel_mask = '0;
    case (cmd)
      CMD_OSZC: sel_mask = 8'h2D;
      CMD_SZC:  sel_mask = 8'h0D;
      CMD_OSZ:  sel_mask = 8'h2C;
      CMD_SZ:   sel_mask = 8'h0C;
      CMD_ZC:   sel_mask = 8'h05;
      CMD_C:    sel_mask = 8'h01;
      default:  sel_mask = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= '0;
    else if (wr_en)
      flags_q <= (flags_q & ~wr_mask) | (wr_bits & wr_mask);
    else if (upd_en)
      flags_q <= (flags_q & ~sel_mask) | (calc & sel_mask);
  end

  function automatic logic low_zero(logic [RES_W-1:0] r, logic [SZW-1:0] sz);
    logic [RES_W-2:0] t;
    t = r[RES_W-2:0] << (8 * (MAX_BYTES - 1 - int'(sz)));
    return t == '0;
  endfunction

  function automatic logic top_sign(logic [RES_W-1:0] r, logic [SZW-1:0] sz);
    logic [RES_W-1:0] t;
    t = r >> (8 * int'(sz) + 7);
    return t[0];
  endfunction

  p_keep_sys_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en) |=> ({flags_q[7:6], flags_q[4], flags_q[1]} ==
                            $past({flags_q[7:6], flags_q[4], flags_q[1]})));

  p_bad_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && cmd[2:1] == 2'b11) |=> (flags_q == $past(flags_q)));

  p_zero_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && cmd <= 3'd4) |=> (flags_q[BIT_Z] == $past(low_zero(result, size_sel))));

  p_sign_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && cmd <= 3'd3) |=> (flags_q[BIT_S] == $past(top_sign(result, size_sel))));

  p_no_ext_ovf_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && cmd == 3'd2 && size_sel == SZW'(MAX_BYTES - 1)) |=> !flags_q[BIT_O]);

  p_carry_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en && cmd == 3'd5) |=>
      (flags_q[BIT_C] == $past(carry_in) && flags_q[7:1] == $past(flags_q[7:1])));

  p_write_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flags_q & $past(wr_mask)) == ($past(wr_bits) & $past(wr_mask))) &&
              ((flags_q & ~$past(wr_mask)) == ($past(flags_q) & ~$past(wr_mask))));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !wr_en) |=> $stable(flags_q));

endmodule

// File: tb/flag_update_unit_tb_top.sv
`timescale 1ns/1ps
module flag_update_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [2:0]  cmd = '0;
  logic [1:0]  size_sel = '0;
  logic [32:0] result = '0;
  logic        carry_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_mask = '0;
  logic [7:0]  wr_bits = '0;
  logic [7:0]  flags_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q = '0;

  always #4 clk = ~clk;

  flag_update_unit dut_i (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .cmd(cmd), .size_sel(size_sel),
    .result(result), .carry_in(carry_in), .wr_en(wr_en), .wr_mask(wr_mask),
    .wr_bits(wr_bits), .flags_q(flags_q)
  );

  function automatic logic [7:0] subset_of(int c);
    case (c)
      0: return 8'h2D;
      1: return 8'h0D;
      2: return 8'h2C;
      3: return 8'h0C;
      4: return 8'h05;
      5: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] model_flags(int c, int nbytes, longint v, bit cy);
    longint msk, hi, smax, smin;
    logic [7:0] f;
    msk  = (64'sd1 <<< (8 * nbytes)) - 1;
    hi   = v & ~msk;
    smax = (64'sd1 <<< (8 * nbytes - 1)) - 1;
    smin = -(64'sd1 <<< (8 * nbytes - 1));
    f = '0;
    f[0] = cy;
    f[2] = ((v & msk) == 0);
    f[3] = ((v >>> (8 * nbytes - 1)) & 1) != 0;
    if (c == 0) f[5] = (v > smax) || (v < smin);
    else        f[5] = (hi != 0) && (hi != ~msk);
    return f;
  endfunction

  task automatic check(string req, string what);
    n_chk++;
    if (flags_q !== exp_q) begin
      n_bad++;
      $display("FAIL %s %s: flags=%02h expected=%02h", req, what, flags_q, exp_q);
    end
  endtask

  task automatic do_update(int c, int nbytes, longint v, bit cy, string req);
    logic [7:0] m;
    @(negedge clk);
    upd_en = 1'b1; cmd = 3'(c); size_sel = 2'(nbytes - 1);
    result = v[32:0]; carry_in = cy;
    m = subset_of(c);
    exp_q = (exp_q & ~m) | (model_flags(c, nbytes, v, cy) & m);
    @(negedge clk);
    upd_en = 1'b0;
    check(req, $sformatf("cmd=%0d size=%0d val=%0d cy=%0d", c, nbytes, v, cy));
  endtask

  task automatic do_write(logic [7:0] m, logic [7:0] b, string req);
    @(negedge clk);
    wr_en = 1'b1; wr_mask = m; wr_bits = b;
    exp_q = (exp_q & ~m) | (b & m);
    @(negedge clk);
    wr_en = 1'b0;
    check(req, $sformatf("write mask=%02h bits=%02h", m, b));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    exp_q = '0;
    check("R1", "during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release");
  endtask

  task automatic t_range_ovf;
    do_update(0, 1, 0, 1'b1, "R4 R8");
    do_update(0, 1, 128, 1'b0, "R6 R5");
    do_update(0, 1, -129, 1'b0, "R6");
    do_update(0, 1, 255, 1'b1, "R6");
    do_update(0, 1, 256, 1'b0, "R6 R4");
    do_update(0, 1, -128, 1'b0, "R6 R5");
    do_update(0, 4, 64'sd2147483648, 1'b1, "R6 R12");
    do_update(0, 4, -64'sd2147483648, 1'b0, "R6 R12");
  endtask

  task automatic t_ext_ovf;
    do_update(2, 1, 255, 1'b0, "R7");
    do_update(2, 1, 256, 1'b0, "R7");
    do_update(2, 1, -1, 1'b0, "R7 R5");
    do_update(2, 4, 64'sd2147483648, 1'b0, "R7");
    do_update(2, 4, -64'sd4294967296, 1'b0, "R7 R4");
  endtask

  task automatic t_sizes;
    do_update(1, 2, 32'h0001_0000, 1'b1, "R12 R4");
    do_update(1, 2, 32'h0000_8000, 1'b0, "R12 R5");
    do_update(3, 3, 32'h0100_0000, 1'b0, "R12 R4");
    do_update(3, 3, 32'h0080_0001, 1'b0, "R12 R5");
    do_update(0, 3, 32'h0080_0000, 1'b0, "R12 R6");
  endtask

  task automatic t_subsets;
    do_write(8'hFF, 8'hFF, "R9");
    do_update(3, 1, 1, 1'b0, "R3 R2");
    do_update(4, 1, 1, 1'b0, "R3");
    do_write(8'hFF, 8'hD2, "R9");
    do_update(5, 1, 0, 1'b1, "R3 R8 R2");
    do_update(1, 1, 8'h80, 1'b0, "R3");
    do_update(2, 1, 256, 1'b1, "R3");
    do_update(6, 1, 0, 1'b1, "R3");
    do_update(7, 2, 32'h8000, 1'b1, "R3");
  endtask

  task automatic t_write;
    do_write(8'h5A, 8'hFF, "R9");
    do_write(8'h0F, 8'h00, "R9");
    do_write(8'hC0, 8'h40, "R9 R2");
  endtask

  task automatic t_priority;
    @(negedge clk);
    wr_en = 1'b1; wr_mask = 8'h05; wr_bits = 8'h00;
    upd_en = 1'b1; cmd = 3'd0; size_sel = 2'd0; result = 33'd0; carry_in = 1'b1;
    exp_q = exp_q & ~8'h05;
    @(negedge clk);
    wr_en = 1'b0; upd_en = 1'b0;
    check("R10", "write and update together");
  endtask

  task automatic t_idle;
    do_write(8'hFF, 8'hA5, "R9");
    @(negedge clk);
    cmd = 3'd0; result = 33'd0; carry_in = 1'b1; wr_mask = 8'hFF; wr_bits = 8'h00;
    repeat (3) @(negedge clk);
    check("R11", "no strobe for three edges");
  endtask

  initial begin
    t_reset;
    t_range_ovf;
    t_ext_ovf;
    t_sizes;
    t_subsets;
    t_write;
    t_priority;
    t_idle;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule